// File: doc/BRIEF.md
# AIS Radio Packet to AIVDM Sentence Formatter

This block turns one received AIS radio packet, held in an external packet store, into one or more AIVDM text sentences. The caller gives the total stored length and a `start` pulse. The stored packet is a channel index byte, then the payload bytes, then two CRC bytes. The block fetches bytes one at a time through a request/valid handshake. It drives printable ASCII characters, one per handshake, on a valid/ready byte stream that feeds a serial transmitter.

The payload is cut into fragments of at most 42 bytes. Each fragment gets its own sentence, with a header, a six-bit armored payload, a fill-bit digit and an XOR checksum, and each sentence ends with carriage return and line feed. A message sequence number is kept from one packet to the next. After the last character of the last sentence, or when a packet is rejected, the block gives a single-cycle `done` so that the caller can discard the stored packet.

States: `ST_IDLE` waits for `start`. It moves to `ST_FINISH` for an undersized packet and to `ST_SIZE` otherwise. `ST_SIZE` counts fragments one chunk per cycle. It moves to `ST_FINISH` if the count would pass nine and to `ST_CHAN` otherwise. `ST_CHAN` fetches the channel byte and moves to `ST_HEAD`. `ST_HEAD` emits the header and moves to `ST_BODY` after its final comma. `ST_BODY` fetches and armors payload bits and moves to `ST_TAIL` when the fragment is empty. `ST_TAIL` emits the fill digit, checksum and line end. It then moves to `ST_HEAD` for the next fragment, or to `ST_FINISH`. `ST_FINISH` pulses `done` and returns to `ST_IDLE`.

Top module: `aivdm_sentence_fmt`

## Requirements
- R1: After reset `busy`, `tx_valid`, `rd_req` and `done` are low. The sequence number starts at 0. `start` is acted on only while `busy` is low.
- R2: A packet whose total length `pkt_len` is below 4 is rejected. No byte is requested, no character is sent, and `done` pulses with `dropped` high.
- R3: The first stored byte is the channel index. It appears in the channel field as ASCII 'A' plus its value.
- R4: The payload is `pkt_len`-3 bytes, read in order. Each fragment carries up to 42 of them, with only the last fragment shorter. Fragment total and fragment number (from 1) are single ASCII digits. A packet needing more than 9 fragments is rejected as in R2.
- R5: Each accepted multi-fragment packet advances the sequence number to the next value in 1..9, with 9 followed by 1. Its sentences carry that digit. A single-fragment sentence leaves the field empty. Rejected packets do not advance it.
- R6: A sentence is `$AIVDM,` total `,` number `,` sequence `,` channel `,` payload `,` fill `*` hex-high hex-low CR LF.
- R7: Payload bits are taken MSB first through the bytes in 6-bit groups. A group v is sent as ASCII v+48, or v+56 when v>39.
- R8: A trailing partial group is padded with zero bits on the right. The pad count (0..5) is the fill digit.
- R9: The checksum is the XOR of all characters between `$` and `*`, exclusive. It is sent as two uppercase hex digits, high nibble first.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays constant.
- R11: `rd_req` stays high until `rd_vld`. A byte is taken in each cycle where both are high. Exactly 1+payload bytes are taken, and the CRC bytes are never requested.
- R12: `done` is a one-cycle pulse after the final LF, with `dropped` low, and no character is sent in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin formatting the stored packet |
| pkt_len | input | LEN_W | Total stored bytes: channel, payload and two CRC bytes |
| busy | output | 1 | A packet is being handled |
| rd_req | output | 1 | Request for the next stored byte |
| rd_data | input | 8 | Stored byte, valid with `rd_vld` |
| rd_vld | input | 1 | `rd_data` holds the requested byte |
| tx_data | output | 8 | ASCII character out |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Transmitter accepts the character |
| done | output | 1 | One-cycle end-of-packet pulse |
| dropped | output | 1 | With `done`: the packet was rejected |

## Verification
The bench targets the length edges: total length 3 against 4, a payload of exactly 84 against 43 bytes, and 378 against 379 payload bytes. An off-by-one in the fragment split would yield a spurious empty fragment, a 43-byte sentence, or a 10-fragment output instead of a rejection. Payload sizes cover every residue of bit count modulo 6. A wrong pad shift would corrupt the last armored character, and a wrong pad count would corrupt the fill digit and therefore the checksum. Seven multi-fragment packets in a row push the sequence digit past 9 to check the wrap to 1. A rejected packet between them would show a skipped digit if it advanced the counter. Random back-pressure on `tx_ready` exposes any lost or repeated character, and a byte count after each packet shows any extra read.

// File: rtl/aivdm_fmt_pkg.sv
package aivdm_fmt_pkg;

    localparam int BYTE_W  = 8;
    localparam int GROUP_W = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SIZE,
        ST_CHAN,
        ST_HEAD,
        ST_BODY,
        ST_TAIL,
        ST_FINISH
    } fmt_state_e;

    localparam logic [7:0] CH_DOLLAR = 8'h24;
    localparam logic [7:0] CH_COMMA  = 8'h2C;
    localparam logic [7:0] CH_STAR   = 8'h2A;
    localparam logic [7:0] CH_CR     = 8'h0D;
    localparam logic [7:0] CH_LF     = 8'h0A;
    localparam logic [7:0] CH_ZERO   = 8'h30;
    localparam logic [7:0] CH_UPA    = 8'h41;

    // six-bit armoring: v+48, with a gap of 8 above value 39
    function automatic logic [7:0] armor6(input logic [5:0] v);
        logic [7:0] w;
        w = {2'b00, v};
        return (v > 6'd39) ? (w + 8'd56) : (w + 8'd48);
    endfunction

    function automatic logic [7:0] hex_digit(input logic [3:0] n);
        logic [7:0] w;
        w = {4'h0, n};
        return (n < 4'd10) ? (w + 8'h30) : (w + 8'h37);
    endfunction

endpackage

// File: rtl/aivdm_bit_packer.sv
module aivdm_bit_packer
    import aivdm_fmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        load,
    input  logic [7:0]  load_byte,
    input  logic        take,
    output logic [3:0]  bit_cnt,
    output logic [5:0]  group,
    output logic [2:0]  pad_bits
);
    localparam int ACC_W  = GROUP_W + BYTE_W - 1;
    localparam int KEEP_W = ACC_W - BYTE_W;

    logic [ACC_W-1:0] acc_q;
    logic [3:0]       cnt_q;
    logic [ACC_W-1:0] shifted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            acc_q <= {acc_q[KEEP_W-1:0], load_byte};
            cnt_q <= cnt_q + 4'd8;
        end else if (take) begin
            cnt_q <= (cnt_q >= 4'd6) ? (cnt_q - 4'd6) : 4'd0;
        end
    end

    always_comb begin
        if (cnt_q >= 4'd6) begin
            shifted  = acc_q >> (cnt_q - 4'd6);
            pad_bits = 3'd0;
        end else begin
            shifted  = acc_q << (4'd6 - cnt_q);
            pad_bits = 3'(4'd6 - cnt_q);
        end
    end

    assign group   = shifted[GROUP_W-1:0];
    assign bit_cnt = cnt_q;

endmodule

// File: rtl/aivdm_xor_sum.sv
module aivdm_xor_sum (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] ch,
    output logic [7:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sum <= '0;
        else if (clr) sum <= '0;
        else if (upd) sum <= sum ^ ch;
    end
endmodule

// File: rtl/aivdm_msg_seq.sv
module aivdm_msg_seq #(
    parameter int MAX_ID = 9,
    localparam int ID_W  = $clog2(MAX_ID + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bump,
    output logic [ID_W-1:0] id
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            id <= '0;
        else if (bump)
            id <= (id >= ID_W'(MAX_ID)) ? ID_W'(1) : id + ID_W'(1);
    end
endmodule

// File: rtl/aivdm_sentence_fmt.sv
module aivdm_sentence_fmt
    import aivdm_fmt_pkg::*;
#(
    parameter int LEN_W    = 10,
    parameter int CHUNK    = 42,
    parameter int MAX_FRAG = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] pkt_len,
    output logic             busy,
    output logic             rd_req,
    input  logic [7:0]       rd_data,
    input  logic             rd_vld,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic             done,
    output logic             dropped
);
    localparam int CNT_W  = $clog2(CHUNK + 1);
    localparam int FRAG_W = $clog2(MAX_FRAG + 1);
    localparam logic [3:0] HEAD_LAST = 4'd14;
    localparam logic [3:0] TAIL_LAST = 4'd6;

    fmt_state_e state_q, state_d;

    logic [LEN_W-1:0]  size_left_q, pay_left_q;
    logic [CNT_W-1:0]  frag_left_q, chunk_now;
    logic [FRAG_W-1:0] frag_total_q, frag_no_q;
    logic [7:0]        chan_q;
    logic [3:0]        step_q;
    logic [2:0]        fill_q;
    logic              drop_q;

    logic              hs, frag_begin, csum_upd, pk_load, pk_take, seq_bump;
    logic              short_pkt, size_over;
    logic [3:0]        pk_cnt;
    logic [5:0]        pk_group;
    logic [2:0]        pk_pad;
    logic [7:0]        csum;
    logic [FRAG_W-1:0] seq_id;

    assign hs        = tx_valid && tx_ready;
    assign short_pkt = pkt_len < LEN_W'(4);
    assign size_over = size_left_q > LEN_W'(CHUNK);
    assign chunk_now = (pay_left_q > LEN_W'(CHUNK)) ? CNT_W'(CHUNK)
                                                    : pay_left_q[CNT_W-1:0];
    assign frag_begin = (state_q == ST_CHAN && rd_vld) ||
                        (state_q == ST_TAIL && hs && step_q == TAIL_LAST &&
                         pay_left_q != '0);
    assign seq_bump = (state_q == ST_SIZE) && !size_over &&
                      (frag_total_q > FRAG_W'(1));
    assign pk_load  = (state_q == ST_BODY) && rd_req && rd_vld;
    assign pk_take  = (state_q == ST_BODY) && hs;
    assign csum_upd = hs && ((state_q == ST_HEAD && step_q != 4'd0) ||
                             state_q == ST_BODY ||
                             (state_q == ST_TAIL && step_q < 4'd2));

    aivdm_bit_packer u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (frag_begin),
        .load      (pk_load),
        .load_byte (rd_data),
        .take      (pk_take),
        .bit_cnt   (pk_cnt),
        .group     (pk_group),
        .pad_bits  (pk_pad)
    );

    aivdm_xor_sum u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (frag_begin),
        .upd   (csum_upd),
        .ch    (tx_data),
        .sum   (csum)
    );

    aivdm_msg_seq #(.MAX_ID(MAX_FRAG)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (seq_bump),
        .id    (seq_id)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = short_pkt ? ST_FINISH : ST_SIZE;
            ST_SIZE: begin
                if (!size_over)
                    state_d = ST_CHAN;
                else if (frag_total_q == FRAG_W'(MAX_FRAG))
                    state_d = ST_FINISH;
            end
            ST_CHAN:   if (rd_vld) state_d = ST_HEAD;
            ST_HEAD:   if (hs && step_q == HEAD_LAST) state_d = ST_BODY;
            ST_BODY:   if (pk_cnt == 4'd0 && frag_left_q == '0) state_d = ST_TAIL;
            ST_TAIL: begin
                if (hs && step_q == TAIL_LAST)
                    state_d = (pay_left_q != '0) ? ST_HEAD : ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // output logic
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = CH_COMMA;
        rd_req   = 1'b0;
        done     = 1'b0;
        dropped  = 1'b0;
        busy     = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE, ST_SIZE: ;
            ST_CHAN: rd_req = 1'b1;
            ST_HEAD: begin
                tx_valid = 1'b1;
                unique case (step_q)
                    4'd0:    tx_data = CH_DOLLAR;
                    4'd1:    tx_data = 8'h41;
                    4'd2:    tx_data = 8'h49;
                    4'd3:    tx_data = 8'h56;
                    4'd4:    tx_data = 8'h44;
                    4'd5:    tx_data = 8'h4D;
                    4'd7:    tx_data = CH_ZERO + 8'(frag_total_q);
                    4'd9:    tx_data = CH_ZERO + 8'(frag_no_q);
                    4'd11:   tx_data = CH_ZERO + 8'(seq_id);
                    4'd13:   tx_data = CH_UPA + chan_q;
                    default: tx_data = CH_COMMA;
                endcase
            end
            ST_BODY: begin
                if (pk_cnt >= 4'd6 || (frag_left_q == '0 && pk_cnt != 4'd0)) begin
                    tx_valid = 1'b1;
                    tx_data  = armor6(pk_group);
                end else if (frag_left_q != '0) begin
                    rd_req = 1'b1;
                end
            end
            ST_TAIL: begin
                tx_valid = 1'b1;
                unique case (step_q)
                    4'd1:    tx_data = CH_ZERO + 8'(fill_q);
                    4'd2:    tx_data = CH_STAR;
                    4'd3:    tx_data = hex_digit(csum[7:4]);
                    4'd4:    tx_data = hex_digit(csum[3:0]);
                    4'd5:    tx_data = CH_CR;
                    4'd6:    tx_data = CH_LF;
                    default: tx_data = CH_COMMA;
                endcase
            end
            ST_FINISH: begin
                done    = 1'b1;
                dropped = drop_q;
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_left_q  <= '0;
            pay_left_q   <= '0;
            frag_left_q  <= '0;
            frag_total_q <= '0;
            frag_no_q    <= '0;
            chan_q       <= '0;
            step_q       <= '0;
            fill_q       <= '0;
            drop_q       <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                size_left_q  <= pkt_len - LEN_W'(3);
                pay_left_q   <= pkt_len - LEN_W'(3);
                frag_total_q <= FRAG_W'(1);
                drop_q       <= short_pkt;
            end
            if (state_q == ST_SIZE && size_over) begin
                size_left_q  <= size_left_q - LEN_W'(CHUNK);
                frag_total_q <= frag_total_q + FRAG_W'(1);
                if (frag_total_q == FRAG_W'(MAX_FRAG)) drop_q <= 1'b1;
            end
            if (state_q == ST_CHAN && rd_vld) begin
                chan_q    <= rd_data;
                frag_no_q <= FRAG_W'(1);
            end
            if (state_q == ST_HEAD && hs) begin
                if (step_q == HEAD_LAST)
                    step_q <= 4'd0;
                else if (step_q == 4'd10 && frag_total_q == FRAG_W'(1))
                    step_q <= 4'd12;
                else
                    step_q <= step_q + 4'd1;
            end
            if (pk_load) frag_left_q <= frag_left_q - CNT_W'(1);
            if (pk_take && pk_cnt < 4'd6) fill_q <= pk_pad;
            if (state_q == ST_TAIL && hs) begin
                step_q <= step_q + 4'd1;
                if (step_q == TAIL_LAST && pay_left_q != '0)
                    frag_no_q <= frag_no_q + FRAG_W'(1);
            end
            if (frag_begin) begin
                frag_left_q <= chunk_now;
                pay_left_q  <= pay_left_q - LEN_W'(chunk_now);
                step_q      <= 4'd0;
                fill_q      <= 3'd0;
            end
        end
    end

endmodule

// File: rtl/aivdm_fmt_checker.sv
module aivdm_fmt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       rd_req,
    input logic       rd_vld,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       done,
    input logic       dropped
);
    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_vld |=> rd_req);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tx_valid && !rd_req);

    // R2
    drop_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |-> done);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_valid && !rd_req && !done);
endmodule

bind aivdm_sentence_fmt aivdm_fmt_checker u_fmt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .rd_req   (rd_req),
    .rd_vld   (rd_vld),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .done     (done),
    .dropped  (dropped)
);

// File: tb/aivdm_sentence_fmt_bench.sv
module aivdm_sentence_fmt_bench;
    localparam int LEN_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic             busy, rd_req, tx_valid, done, dropped;
    logic [7:0]       rd_data = '0;
    logic             rd_vld = 1'b0;
    logic [7:0]       tx_data;
    logic             tx_ready = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int rd_ptr = 0;
    int model_id = 0;
    bit stall_on = 1'b0;
    bit ended = 1'b0;
    logic [7:0] pkt_mem [0:511];
    logic [7:0] exp_q [$];
    logic [7:0] cs;
    string cur_req = "R6";

    always #5 clk = ~clk;

    aivdm_sentence_fmt #(.LEN_W(LEN_W)) u_aivdm_sentence_fmt (
        .clk(clk), .rst_n(rst_n), .start(start), .pkt_len(pkt_len),
        .busy(busy), .rd_req(rd_req), .rd_data(rd_data), .rd_vld(rd_vld),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .done(done), .dropped(dropped)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // byte source: one-cycle latency, R11 handshake
    initial forever begin
        @(posedge clk);
        if (rd_req && rd_vld) rd_ptr = rd_ptr + 1;
        rd_vld  <= rd_req && !rd_vld;
        rd_data <= pkt_mem[rd_ptr];
    end

    // monitor: scoreboard compare of each accepted character (R10 stalls)
    initial forever begin
        @(negedge clk);
        tx_ready = stall_on ? ($urandom % 3 != 0) : 1'b1;
        #1;
        if (tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                check({cur_req, " extra char"}, int'(tx_data), -1);
            end else begin
                check(cur_req, int'(tx_data), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic put(input logic [7:0] c, input bit incl);
        exp_q.push_back(c);
        if (incl) cs = cs ^ c;
    endtask

    function automatic logic [7:0] arm(input int v);
        return 8'((v > 39) ? v + 56 : v + 48);
    endfunction

    function automatic logic [7:0] hx(input int n);
        return 8'((n < 10) ? n + 48 : n + 55);
    endfunction

    // expected-sentence model built from R3..R9
    task automatic expect_pkt(input int p, input int total);
        int off = 1;
        string lead = "AIVDM,";
        if (total > 1) model_id = (model_id >= 9) ? 1 : model_id + 1;
        for (int f = 1; f <= total; f++) begin
            int fb = (p - (f - 1) * 42 > 42) ? 42 : p - (f - 1) * 42;
            int buf_v = 0;
            int nb = 0;
            int fill = 0;
            cs = 8'h00;
            put(8'h24, 1'b0);
            for (int i = 0; i < lead.len(); i++) put(lead[i], 1'b1);
            put(8'(48 + total), 1'b1); put(8'h2C, 1'b1);
            put(8'(48 + f), 1'b1);     put(8'h2C, 1'b1);
            if (total > 1) put(8'(48 + model_id), 1'b1);
            put(8'h2C, 1'b1);
            put(8'(65 + int'(pkt_mem[0])), 1'b1); put(8'h2C, 1'b1);
            for (int b = 0; b < fb; b++) begin
                buf_v = (buf_v << 8) | int'(pkt_mem[off]);
                off++;
                nb += 8;
                while (nb >= 6) begin
                    put(arm((buf_v >> (nb - 6)) & 63), 1'b1);
                    nb -= 6;
                end
                buf_v = buf_v & ((1 << nb) - 1);
            end
            if (nb > 0) begin
                fill = 6 - nb;
                put(arm((buf_v << fill) & 63), 1'b1);
            end
            put(8'h2C, 1'b1);
            put(8'(48 + fill), 1'b1);
            put(8'h2A, 1'b0);
            put(hx(int'(cs[7:4])), 1'b0);
            put(hx(int'(cs[3:0])), 1'b0);
            put(8'h0D, 1'b0);
            put(8'h0A, 1'b0);
        end
    endtask

    task automatic run_pkt(input string req, input int len, input int chan,
                           input int seed);
        int p = len - 3;
        int total = (p + 41) / 42;
        bit exp_drop = (len < 4) || (total > 9);
        cur_req = req;
        pkt_mem[0] = 8'(chan);
        for (int i = 1; i < 512; i++) pkt_mem[i] = 8'(i * 37 + seed * 11 + i / 5);
        rd_ptr = 0;
        if (!exp_drop) expect_pkt(p, total);
        @(negedge clk);
        pkt_len = LEN_W'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check({req, " dropped flag"}, int'(dropped), int'(exp_drop));
        check({req, " R11 bytes read"}, rd_ptr, exp_drop ? 0 : 1 + p);
        check({req, " leftover chars"}, exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        check({req, " R12 done pulse"}, int'(done), 0);
    endtask

    initial begin
        #1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 tx_valid", int'(tx_valid), 0);
        check("R1 rd_req", int'(rd_req), 0);
        check("R1 done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_pkt("R2 len3", 3, 0, 1);
        run_pkt("R7 R8 len4", 4, 0, 2);
        stall_on = 1'b1;
        run_pkt("R3 R9 len6", 6, 1, 3);
        run_pkt("R8 len8", 8, 2, 4);
        run_pkt("R8 len10", 10, 1, 5);
        run_pkt("R4 R5 two frags", 46, 0, 6);
        run_pkt("R4 exact 84", 87, 1, 7);
        run_pkt("R4 nine frags", 381, 0, 8);
        run_pkt("R4 R5 ten frags dropped", 382, 1, 9);
        for (int k = 0; k < 7; k++) run_pkt("R5 wrap", 46 + k * 5, k % 2, 10 + k);
        check("R5 wrapped id", model_id, 1);
        run_pkt("R5 R6 single after multi", 20, 0, 30);
        stall_on = 1'b0;
        run_pkt("R6 R7 no stall", 45, 1, 31);
        ended = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (%s): actual hung expected done", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule